// File: doc/BRIEF.md
# S-Bus Layer-1 Activation Sequencer

This block sequences the line-signal handshake that brings a basic-rate S-bus link from idle to fully active and back. One parameter selects the side it serves: the network side (`IS_NT = 1`) or the terminal side (`IS_NT = 0`). The block works on abstract line indications that a framing receiver has already decoded. These are whether any signal is present, whether frame lock has been reached, and which Info type is arriving. It also accepts local activate and deactivate requests. It produces the Info type to transmit, the activation bit to place in outgoing frames, and a flag that reports a fully activated link.

The network side answers a terminal's wake-up (Info1), or its own activate request, by sending Info2: frames with empty B and D channels and the activation bit at zero. Once it has locked to Info3, it sends Info4 with the activation bit at one. The terminal side sends Info1 on a local request. When it locks to Info2, it answers with Info3, and it considers itself active once it locks to Info4. If the network starts the activation, the terminal skips Info1 and jumps straight to Info3 when Info2 appears. Either end tears the link down by falling back to Info0, the idle line. A frame counter returns any waiting state to idle if the peer never answers.

All decisions are taken on cycles where `frame_tick` is high, one per line frame. Every output is registered and changes only on the edge that ends such a cycle. There is no streamed data at this block's edge, so it has no valid/ready handshake. All pins are plain level-sensitive control and status signals.

Top module: `sbus_act_ctrl`

## Requirements
- R1: After reset, `tx_info` is 0 (Info0), `tx_abit` is 0 and `activated` is 0.
- R2: State and all outputs change only on a clock edge at which `frame_tick` is high. Inputs presented without `frame_tick` have no effect.
- R3: Network side, idle: on a tick with `act_req` high, or with Info1 received (signal present, lock achieved, `rx_info` = 1), `tx_info` becomes 2 (Info2) with `tx_abit` = 0.
- R4: Network side, sending Info2: on a tick with Info3 received under lock (`rx_info` = 3), `tx_info` becomes 4, `tx_abit` becomes 1 and `activated` becomes 1.
- R5: Terminal side: in idle, `act_req` on a tick makes `tx_info` 1 (Info1). In idle or while sending Info1, Info2 received under lock (`rx_info` = 2) makes `tx_info` 3 (Info3).
- R6: Terminal side, sending Info3 while awaiting Info4: Info4 received under lock (`rx_info` = 4) enters the active state and keeps `tx_info` at 3. In the active state, `activated` follows the received activation bit `rx_abit` as sampled on each tick.
- R7: `deact_req` on a tick returns either side to Info0 from any state and clears `activated` and `tx_abit`.
- R8: Loss of signal (`rx_sig_det` low, i.e. Info0 received) on a tick in the lock-awaiting-Info4 state or in the active state returns the block to Info0.
- R9: In a state that waits for the peer (Info1 sent, Info2 sent, or Info3 sent before activation), the block returns to Info0 on the `TIMEOUT_FRAMES`-th tick after entering that state if no progress occurred. The active state never times out.
- R10: Info types are coded on `tx_info` and `rx_info` as the numbers 0 to 4 for Info0 to Info4.
- R11: The terminal side always drives `tx_abit` = 0.
- R12: Priority on a tick: `deact_req` beats timeout, which beats loss of signal, which beats forward progress. On the terminal side in idle, Info2 received beats `act_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_tick | input | 1 | One-cycle strobe per line frame; decisions are taken here |
| rx_sig_det | input | 1 | Line signal present (low means Info0 received) |
| rx_sync | input | 1 | Frame lock achieved on the received signal |
| rx_info | input | 3 | Decoded received Info type, 0 to 4 |
| rx_abit | input | 1 | Received activation bit (used on the terminal side) |
| act_req | input | 1 | Local request to activate |
| deact_req | input | 1 | Local request to deactivate |
| tx_info | output | 3 | Info type to transmit, 0 to 4 |
| tx_abit | output | 1 | Activation bit for transmitted frames |
| activated | output | 1 | Link fully activated |

## Verification
The bench runs a network-side and a terminal-side instance side by side. It targets inputs that change between ticks, which a design that samples on every clock would act on. It applies `deact_req` together with `act_req`, and a received Info2 together with a terminal `act_req`, where a wrong priority would send Info2 or Info1 instead of Info0 or Info3. It toggles the received activation bit while the terminal is active, which a design that latched `activated` once would miss. It holds both sides in their waiting states for exactly `TIMEOUT_FRAMES` ticks and keeps the network side active past that count, catching an off-by-one counter or a timeout that also tears down an active link.

// File: rtl/sbus_act_pkg.sv
package sbus_act_pkg;
  localparam int INFO_W   = 3;
  localparam int NUM_INFO = 5;

  typedef enum logic [INFO_W-1:0] {
    INFO0 = 3'd0,
    INFO1 = 3'd1,
    INFO2 = 3'd2,
    INFO3 = 3'd3,
    INFO4 = 3'd4
  } info_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_TE_REQ  = 3'd1,
    ST_NT_PEND = 3'd2,
    ST_SYNCED  = 3'd3,
    ST_ACTIVE  = 3'd4
  } act_state_e;
endpackage

// File: rtl/sbus_rx_decode.sv
module sbus_rx_decode
  import sbus_act_pkg::*;
(
  input  logic              sig_det,
  input  logic              sync_ok,
  input  logic [INFO_W-1:0] info,
  output logic [NUM_INFO-1:0] hit
);
  // hit[0]: idle line; hit[k]: Info k received under frame lock
  for (genvar k = 0; k < NUM_INFO; k++) begin : g_hit
    if (k == 0) begin : g_idle
      assign hit[k] = !sig_det;
    end else begin : g_sig
      assign hit[k] = sig_det && sync_ok && (info == INFO_W'(k));
    end
  end
endmodule

// File: rtl/sbus_frame_timer.sv
module sbus_frame_timer #(
  parameter int TIMEOUT_FRAMES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_tick,
  input  logic clear,
  output logic expired
);
  localparam int CW    = $clog2(TIMEOUT_FRAMES + 1);
  localparam int LIMIT = TIMEOUT_FRAMES - 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (frame_tick && (cnt_q != CW'(LIMIT))) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = (cnt_q == CW'(LIMIT));

  assert_tmo_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(cnt_q));
  assert_tmo_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && !clear && cnt_q < CW'(LIMIT)) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/sbus_act_fsm.sv
module sbus_act_fsm
  import sbus_act_pkg::*;
#(
  parameter bit IS_NT = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_tick,
  input  logic [NUM_INFO-1:0] rx_hit,
  input  logic                rx_abit,
  input  logic                act_req,
  input  logic                deact_req,
  input  logic                tmo_expired,
  output logic                tmo_clear,
  output logic [INFO_W-1:0]   tx_info,
  output logic                tx_abit,
  output logic                activated
);
  act_state_e st_q, st_nxt, idle_exit;
  logic       waiting, lost;
  logic [INFO_W-1:0] code_nxt;

  // role-specific wake-up decision and line code per state
  if (IS_NT) begin : g_nt
    always_comb begin
      idle_exit = ST_IDLE;
      if (act_req || rx_hit[1]) idle_exit = ST_NT_PEND;
    end
    always_comb begin
      unique case (st_nxt)
        ST_NT_PEND: code_nxt = INFO2;
        ST_ACTIVE:  code_nxt = INFO4;
        default:    code_nxt = INFO0;
      endcase
    end
  end else begin : g_te
    always_comb begin
      idle_exit = ST_IDLE;
      if (rx_hit[2])    idle_exit = ST_SYNCED;
      else if (act_req) idle_exit = ST_TE_REQ;
    end
    always_comb begin
      unique case (st_nxt)
        ST_TE_REQ:            code_nxt = INFO1;
        ST_SYNCED, ST_ACTIVE: code_nxt = INFO3;
        default:              code_nxt = INFO0;
      endcase
    end
  end

  assign waiting = (st_q == ST_TE_REQ) || (st_q == ST_NT_PEND) || (st_q == ST_SYNCED);
  assign lost    = ((st_q == ST_SYNCED) || (st_q == ST_ACTIVE)) && rx_hit[0];

  always_comb begin
    st_nxt = st_q;
    if (deact_req) begin
      st_nxt = ST_IDLE;
    end else if (waiting && tmo_expired) begin
      st_nxt = ST_IDLE;
    end else if (lost) begin
      st_nxt = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE:    st_nxt = idle_exit;
        ST_TE_REQ:  if (rx_hit[2]) st_nxt = ST_SYNCED;
        ST_NT_PEND: if (rx_hit[3]) st_nxt = ST_ACTIVE;
        ST_SYNCED:  if (rx_hit[4]) st_nxt = ST_ACTIVE;
        default:    st_nxt = st_q;
      endcase
    end
  end

  assign tmo_clear = frame_tick && (st_nxt != st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      tx_info   <= INFO0;
      tx_abit   <= 1'b0;
      activated <= 1'b0;
    end else if (frame_tick) begin
      st_q      <= st_nxt;
      tx_info   <= code_nxt;
      tx_abit   <= IS_NT && (st_nxt == ST_ACTIVE);
      activated <= (st_nxt == ST_ACTIVE) && (IS_NT || rx_abit);
    end
  end

  assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> ($stable(tx_info) && $stable(activated) && $stable(tx_abit)));
  assert_deact_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && deact_req) |=> (tx_info == INFO0 && !activated && !tx_abit));
  assert_loss_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && st_q == ST_ACTIVE && rx_hit[0]) |=> tx_info == INFO0);
  assert_act_only_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
    activated |-> st_q == ST_ACTIVE);
  assert_abit_with_info4_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abit |-> tx_info == INFO4);
endmodule

// File: rtl/sbus_act_ctrl.sv
module sbus_act_ctrl
  import sbus_act_pkg::*;
#(
  parameter bit IS_NT          = 1'b1,
  parameter int TIMEOUT_FRAMES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic              rx_sig_det,
  input  logic              rx_sync,
  input  logic [INFO_W-1:0] rx_info,
  input  logic              rx_abit,
  input  logic              act_req,
  input  logic              deact_req,
  output logic [INFO_W-1:0] tx_info,
  output logic              tx_abit,
  output logic              activated
);
  logic [NUM_INFO-1:0] rx_hit;
  logic                tmo_clear, tmo_expired;

  sbus_rx_decode u_dec (
    .sig_det (rx_sig_det),
    .sync_ok (rx_sync),
    .info    (rx_info),
    .hit     (rx_hit)
  );

  sbus_frame_timer #(.TIMEOUT_FRAMES(TIMEOUT_FRAMES)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (frame_tick),
    .clear      (tmo_clear),
    .expired    (tmo_expired)
  );

  sbus_act_fsm #(.IS_NT(IS_NT)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_tick  (frame_tick),
    .rx_hit      (rx_hit),
    .rx_abit     (rx_abit),
    .act_req     (act_req),
    .deact_req   (deact_req),
    .tmo_expired (tmo_expired),
    .tmo_clear   (tmo_clear),
    .tx_info     (tx_info),
    .tx_abit     (tx_abit),
    .activated   (activated)
  );
endmodule

// File: tb/test_sbus_act_ctrl.sv
module test_sbus_act_ctrl;
  localparam int TMO = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_tick = 1'b0;
  logic n_sig = 0, n_sync = 0, n_abit = 0, n_act = 0, n_deact = 0;
  logic t_sig = 0, t_sync = 0, t_abit = 0, t_act = 0, t_deact = 0;
  logic [2:0] n_info = 3'd0, t_info = 3'd0;
  logic [2:0] n_tx, t_tx;
  logic n_txa, t_txa, n_on, t_on;

  always #10 clk = ~clk; // 50 MHz

  sbus_act_ctrl #(.IS_NT(1'b1), .TIMEOUT_FRAMES(TMO)) i_sbus_act_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
    .rx_sig_det(n_sig), .rx_sync(n_sync), .rx_info(n_info), .rx_abit(n_abit),
    .act_req(n_act), .deact_req(n_deact),
    .tx_info(n_tx), .tx_abit(n_txa), .activated(n_on));

  sbus_act_ctrl #(.IS_NT(1'b0), .TIMEOUT_FRAMES(TMO)) i_sbus_act_ctrl_te (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
    .rx_sig_det(t_sig), .rx_sync(t_sync), .rx_info(t_info), .rx_abit(t_abit),
    .act_req(t_act), .deact_req(t_deact),
    .tx_info(t_tx), .tx_abit(t_txa), .activated(t_on));

  typedef struct {
    int         due;
    bit         te;
    logic [2:0] info;
    logic       abit;
    logic       on;
    string      tag;
  } exp_t;

  exp_t sb[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops every item due in this cycle and compares
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due == cyc) begin
      exp_t e;
      logic [2:0] ai;
      logic aa, ao;
      e  = sb.pop_front();
      ai = e.te ? t_tx  : n_tx;
      aa = e.te ? t_txa : n_txa;
      ao = e.te ? t_on  : n_on;
      checks++;
      if (ai !== e.info || aa !== e.abit || ao !== e.on) begin
        errors++;
        $display("FAIL %s %s: actual info=%0d abit=%0b act=%0b expected info=%0d abit=%0b act=%0b",
                 e.tag, e.te ? "TE" : "NT", ai, aa, ao, e.info, e.abit, e.on);
      end
    end
  end

  task automatic push(string tag, logic [2:0] ni, logic na, logic nc,
                      logic [2:0] ti, logic ta, logic tc);
    exp_t e;
    e.due = cyc + 1; e.tag = tag;
    e.te = 1'b0; e.info = ni; e.abit = na; e.on = nc; sb.push_back(e);
    e.te = 1'b1; e.info = ti; e.abit = ta; e.on = tc; sb.push_back(e);
  endtask

  task automatic frame(string tag, logic [2:0] ni, logic na, logic nc,
                       logic [2:0] ti, logic ta, logic tc);
    @(negedge clk);
    frame_tick = 1'b1;
    push(tag, ni, na, nc, ti, ta, tc);
    @(negedge clk);
    frame_tick = 1'b0;
  endtask

  task automatic idle_check(string tag, logic [2:0] ni, logic na, logic nc,
                            logic [2:0] ti, logic ta, logic tc);
    @(negedge clk);
    push(tag, ni, na, nc, ti, ta, tc);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R2: actual run hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle_check("R1_reset", 3'd0, 0, 0, 3'd0, 0, 0);

    // activation requests on both sides
    n_act = 1; t_act = 1;
    frame("R3/R5_request", 3'd2, 0, 0, 3'd1, 0, 0);
    n_act = 0; t_act = 0;
    // inputs change with no tick: nothing may move
    t_sig = 1; t_sync = 1; t_info = 3'd2;
    n_sig = 1; n_sync = 1; n_info = 3'd3;
    idle_check("R2_no_tick", 3'd2, 0, 0, 3'd1, 0, 0);
    frame("R4/R5_lock", 3'd4, 1, 1, 3'd3, 0, 0);
    t_info = 3'd4; t_abit = 0;
    frame("R6_abit_low_R11", 3'd4, 1, 1, 3'd3, 0, 0);
    t_abit = 1;
    frame("R6_abit_high_R10", 3'd4, 1, 1, 3'd3, 0, 1);
    t_abit = 0;
    frame("R6_abit_drop", 3'd4, 1, 1, 3'd3, 0, 0);
    t_abit = 1;
    frame("R6_abit_back", 3'd4, 1, 1, 3'd3, 0, 1);
    frame("R9_active_no_timeout", 3'd4, 1, 1, 3'd3, 0, 1);
    // NT loses signal, TE deactivates locally
    n_sig = 0; t_deact = 1;
    frame("R8/R7_teardown", 3'd0, 0, 0, 3'd0, 0, 0);
    t_deact = 0;
    // TE: Info2 wins over act_req; NT woken by Info1
    n_sig = 1; n_sync = 1; n_info = 3'd1;
    t_sig = 1; t_sync = 1; t_info = 3'd2; t_act = 1; t_abit = 0;
    frame("R12/R3_wake", 3'd2, 0, 0, 3'd3, 0, 0);
    t_act = 0;
    // no progress: both wait TMO ticks then drop to idle
    for (int k = 1; k < TMO; k++)
      frame("R9_waiting", 3'd2, 0, 0, 3'd3, 0, 0);
    frame("R9_timeout", 3'd0, 0, 0, 3'd0, 0, 0);
    n_sig = 0; t_sig = 0;
    frame("R9_stay_idle", 3'd0, 0, 0, 3'd0, 0, 0);
    // TE loss of signal while awaiting Info4
    t_sig = 1; t_info = 3'd2;
    frame("R5_sync_again", 3'd0, 0, 0, 3'd3, 0, 0);
    t_sig = 0;
    frame("R8_te_loss", 3'd0, 0, 0, 3'd0, 0, 0);
    // deactivate during pending, and deact beats act
    n_act = 1;
    frame("R3_local_act", 3'd2, 0, 0, 3'd0, 0, 0);
    n_act = 0; n_deact = 1;
    frame("R7_deact_pending", 3'd0, 0, 0, 3'd0, 0, 0);
    n_act = 1; t_act = 1; t_deact = 1;
    frame("R12_deact_wins", 3'd0, 0, 0, 3'd0, 0, 0);
    n_act = 0; n_deact = 0; t_act = 0; t_deact = 0;
    idle_check("R1_quiet", 3'd0, 0, 0, 3'd0, 0, 0);

    repeat (2) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule